// File: doc/BRIEF.md
# Host Controller Command Register with Async-Advance Doorbell

This block holds the command word, the async-advance interrupt status and its enable for a host controller. Software reaches it through a simple 32-bit bus port. A write strobe applies a write in the clock cycle where it is high. Reads are combinational from the byte offset. The controller side receives the schedule enables, the frame list size and the matching frame index mask, and a light reset request. The controller returns three pulses: eviction complete, light reset complete and the interrupt threshold tick.

Software rings a doorbell to ask the controller to tell it when the asynchronous schedule has advanced. Once the controller reports that cached schedule state has been evicted, the block clears the doorbell and raises the async-advance status bit in the same clock edge. If that status is enabled, the interrupt line is held back until the next threshold tick. Writing 1 to the status bit clears it, and the interrupt drops with it.

The size field only takes writes when a capability strap is high. A parameter selects whether light reset exists. When it does not, the light reset bit always reads 0.

Top module: `hc_cmd_reg`

## Requirements
- R1: After reset, the command word (offset 0x0), the status word (offset 0x4) and the enable word (offset 0x8) all read 0. `async_en`, `periodic_en`, `lrst_req` and `irq` are 0, `fl_size` is 00 and `fidx_mask` is 0x3FF.
- R2: Command bit 5 is the asynchronous schedule enable and bit 4 is the periodic schedule enable. Both are read/write, and both drive `async_en` and `periodic_en` directly from the stored value.
- R3: Command bits 3:2 hold the frame list size. A write changes the field only while `prog_fl_cap` is 1 and the written code is not the reserved code 11. In every other case the field keeps its value.
- R4: `fidx_mask` has 10, 9 or 8 low bits set (0x3FF, 0x1FF, 0x0FF) for size codes 00 (1024 entries), 01 (512 entries) and 10 (256 entries).
- R5: Writing 1 to command bit 6 sets the doorbell. Writing 0 to bit 6 leaves the doorbell unchanged.
- R6: On a clock edge where `evict_done` is high and the doorbell is set, the doorbell clears and status bit 5 (async-advance status) sets, both on that same edge.
- R7: An `evict_done` pulse while the doorbell is clear changes neither the doorbell nor status bit 5.
- R8: While status bit 5 and enable bit 5 (offset 0x8) are both 1, `irq` rises on the edge after the first `thr_tick` that is sampled with both bits already set. It never rises without a tick.
- R9: Writing 1 to status bit 5 clears that bit, and `irq` falls on the same edge. Clearing enable bit 5 also drops `irq` on the same edge.
- R10: When light reset is supported, writing 1 to command bit 7 sets that bit and `lrst_req`. Both stay at 1 until an `lrst_done` pulse clears them. When light reset is not supported, bit 7 always reads 0.
- R11: Command bits 31:8 and 1:0 read 0. Any offset other than 0x0, 0x4 and 0x8 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle high |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| prog_fl_cap | input | 1 | Strap: frame list size is programmable |
| async_en | output | 1 | Process the asynchronous schedule |
| periodic_en | output | 1 | Process the periodic schedule |
| fl_size | output | 2 | Frame list size code |
| fidx_mask | output | FIDX_W | Low-bit mask for the frame list index |
| lrst_req | output | 1 | Light reset in progress |
| evict_done | input | 1 | Controller has evicted cached schedule state |
| lrst_done | input | 1 | Controller has completed the light reset |
| thr_tick | input | 1 | Interrupt threshold tick |
| irq | output | 1 | Interrupt output |

## Verification
The bench targets several corner cases, and each would expose a specific fault:
- Eviction with no doorbell pending: a design that honoured it would raise a false status.
- A zero written to the doorbell bit: a design that treated the bit as plain storage would cancel a pending doorbell.
- A threshold tick in the same cycle the status sets: an eager design would fire the interrupt early.
- A tick with the enable off: the interrupt must stay low.
- The reserved size code, and size writes with the strap low: a design that failed here would corrupt the index mask.
- A second instance with light reset removed: bit 7 must stay at 0.

// File: rtl/hc_cmd_pkg.sv
package hc_cmd_pkg;
  // command word bit positions (decoded by the controller side)
  localparam int unsigned CMD_PSE_BIT  = 4;
  localparam int unsigned CMD_ASE_BIT  = 5;
  localparam int unsigned CMD_DB_BIT   = 6;
  localparam int unsigned CMD_LRST_BIT = 7;
  localparam int unsigned CMD_FLS_LO   = 2;
  // status / enable bit for async-advance
  localparam int unsigned IAA_BIT      = 5;

  typedef enum logic [1:0] {
    FLS_1024 = 2'b00,
    FLS_512  = 2'b01,
    FLS_256  = 2'b10,
    FLS_RSVD = 2'b11
  } fls_code_e;
endpackage

// File: rtl/hc_cmd_fields.sv
module hc_cmd_fields
  import hc_cmd_pkg::*;
#(
  parameter int unsigned FIDX_W       = 10,
  parameter bit          LRST_SUPPORT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmd,
  input  logic              wr_ase,
  input  logic              wr_pse,
  input  logic [1:0]        wr_fls,
  input  logic              wr_lrst,
  input  logic              prog_cap,
  input  logic              lrst_done,
  output logic              ase_q,
  output logic              pse_q,
  output logic [1:0]        fls_q,
  output logic              lrst_q,
  output logic [FIDX_W-1:0] fidx_mask
);

  logic       ase_d, pse_d;
  logic [1:0] fls_d;
  logic       fls_wr_ok;

  assign fls_wr_ok = wr_cmd && prog_cap && (wr_fls != FLS_RSVD);

  always_comb begin
    ase_d = ase_q;
    pse_d = pse_q;
    fls_d = fls_q;
    if (wr_cmd) begin
      ase_d = wr_ase;
      pse_d = wr_pse;
    end
    if (fls_wr_ok) fls_d = wr_fls;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ase_q <= 1'b0;
      pse_q <= 1'b0;
      fls_q <= FLS_1024;
    end else begin
      ase_q <= ase_d;
      pse_q <= pse_d;
      fls_q <= fls_d;
    end
  end

  // index mask: one fewer low bit for each halving of the list
  assign fidx_mask = {FIDX_W{1'b1}} >> fls_q;

  generate
    if (LRST_SUPPORT) begin : g_lrst
      logic lrst_d;
      always_comb begin
        lrst_d = lrst_q;
        if (lrst_q && lrst_done)    lrst_d = 1'b0;
        else if (wr_cmd && wr_lrst) lrst_d = 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lrst_q <= 1'b0;
        else        lrst_q <= lrst_d;
      end
      p_lrst_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lrst_q && lrst_done) |=> !lrst_q);
      p_lrst_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lrst_q && !lrst_done) |=> lrst_q);
    end else begin : g_no_lrst
      assign lrst_q = 1'b0;
    end
  endgenerate

  p_fls_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_cap |=> $stable(fls_q));
  p_fls_no_rsvd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && wr_fls == FLS_RSVD) |=> $stable(fls_q));
  p_ase_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |=> (ase_q == $past(wr_ase)) && (pse_q == $past(wr_pse)));

endmodule

// File: rtl/hc_iaa_ctl.sv
module hc_iaa_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_cmd,
  input  logic wr_db,
  input  logic wr_sts,
  input  logic clr_iaa,
  input  logic wr_ien,
  input  logic ien_val,
  input  logic evict_done,
  input  logic thr_tick,
  output logic db_q,
  output logic sts_q,
  output logic en_q,
  output logic irq_q
);

  logic db_d, sts_d, en_d, irq_d;
  logic evict_hit;

  assign evict_hit = evict_done && db_q;

  always_comb begin
    db_d  = db_q;
    sts_d = sts_q;
    en_d  = en_q;
    if (evict_hit)              db_d = 1'b0;
    else if (wr_cmd && wr_db)   db_d = 1'b1;
    if (evict_hit)              sts_d = 1'b1;
    else if (wr_sts && clr_iaa) sts_d = 1'b0;
    if (wr_ien)                 en_d = ien_val;
    // fire only on a tick that sees status already set and enabled;
    // drop on the same edge that removes status or enable
    irq_d = sts_d && en_d && (irq_q || (thr_tick && sts_q && en_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_q  <= 1'b0;
      sts_q <= 1'b0;
      en_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      db_q  <= db_d;
      sts_q <= sts_d;
      en_q  <= en_d;
      irq_q <= irq_d;
    end
  end

  p_db_evict_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_done && db_q) |=> (!db_q && sts_q));
  p_evict_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_done && !db_q && !wr_cmd && !wr_sts) |=> (!db_q && $stable(sts_q)));
  p_irq_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(thr_tick));
  p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && clr_iaa && !(evict_done && db_q)) |=> !irq_q);
  p_db_zero_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (db_q && !evict_done) |=> db_q);

endmodule

// File: rtl/hc_cmd_reg.sv
module hc_cmd_reg
  import hc_cmd_pkg::*;
#(
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned FIDX_W       = 10,
  parameter bit          LRST_SUPPORT = 1'b1,
  parameter logic [ADDR_W-1:0] OFS_CMD = 'h0,
  parameter logic [ADDR_W-1:0] OFS_STS = 'h4,
  parameter logic [ADDR_W-1:0] OFS_IEN = 'h8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              prog_fl_cap,
  output logic              async_en,
  output logic              periodic_en,
  output logic [1:0]        fl_size,
  output logic [FIDX_W-1:0] fidx_mask,
  output logic              lrst_req,
  input  logic              evict_done,
  input  logic              lrst_done,
  input  logic              thr_tick,
  output logic              irq
);

  logic wr_cmd, wr_sts, wr_ien;
  logic ase_q, pse_q, lrst_q, db_q, sts_q, en_q, irq_q;
  logic [1:0] fls_q;

  assign wr_cmd = bus_wr && (bus_addr == OFS_CMD);
  assign wr_sts = bus_wr && (bus_addr == OFS_STS);
  assign wr_ien = bus_wr && (bus_addr == OFS_IEN);

  hc_cmd_fields #(
    .FIDX_W       (FIDX_W),
    .LRST_SUPPORT (LRST_SUPPORT)
  ) u_fields (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_cmd    (wr_cmd),
    .wr_ase    (bus_wdata[CMD_ASE_BIT]),
    .wr_pse    (bus_wdata[CMD_PSE_BIT]),
    .wr_fls    (bus_wdata[CMD_FLS_LO +: 2]),
    .wr_lrst   (bus_wdata[CMD_LRST_BIT]),
    .prog_cap  (prog_fl_cap),
    .lrst_done (lrst_done),
    .ase_q     (ase_q),
    .pse_q     (pse_q),
    .fls_q     (fls_q),
    .lrst_q    (lrst_q),
    .fidx_mask (fidx_mask)
  );

  hc_iaa_ctl u_iaa (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_cmd     (wr_cmd),
    .wr_db      (bus_wdata[CMD_DB_BIT]),
    .wr_sts     (wr_sts),
    .clr_iaa    (bus_wdata[IAA_BIT]),
    .wr_ien     (wr_ien),
    .ien_val    (bus_wdata[IAA_BIT]),
    .evict_done (evict_done),
    .thr_tick   (thr_tick),
    .db_q       (db_q),
    .sts_q      (sts_q),
    .en_q       (en_q),
    .irq_q      (irq_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_CMD) begin
      bus_rdata[CMD_PSE_BIT]      = pse_q;
      bus_rdata[CMD_ASE_BIT]      = ase_q;
      bus_rdata[CMD_DB_BIT]       = db_q;
      bus_rdata[CMD_LRST_BIT]     = lrst_q;
      bus_rdata[CMD_FLS_LO +: 2]  = fls_q;
    end else if (bus_addr == OFS_STS) begin
      bus_rdata[IAA_BIT] = sts_q;
    end else if (bus_addr == OFS_IEN) begin
      bus_rdata[IAA_BIT] = en_q;
    end
  end

  assign async_en    = ase_q;
  assign periodic_en = pse_q;
  assign fl_size     = fls_q;
  assign lrst_req    = lrst_q;
  assign irq         = irq_q;

  p_irq_needs_sts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts_q && en_q));
  p_mask_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fidx_mask[0]);

endmodule

// File: tb/hc_cmd_reg_test.sv
module hc_cmd_reg_test;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 8;
  localparam int unsigned FW = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_wr;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata, rdata_nolr;
  logic          prog_fl_cap, evict_done, lrst_done, thr_tick;
  logic          async_en, periodic_en, lrst_req, irq;
  logic [1:0]    fl_size;
  logic [FW-1:0] fidx_mask;
  logic          n_async, n_periodic, n_lrst, n_irq;
  logic [1:0]    n_fls;
  logic [FW-1:0] n_mask;

  int checks = 0;
  int fails  = 0;
  int viol   = 0;

  always #4 clk = ~clk;

  hc_cmd_reg uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .prog_fl_cap(prog_fl_cap),
    .async_en(async_en), .periodic_en(periodic_en), .fl_size(fl_size),
    .fidx_mask(fidx_mask), .lrst_req(lrst_req), .evict_done(evict_done),
    .lrst_done(lrst_done), .thr_tick(thr_tick), .irq(irq)
  );

  hc_cmd_reg #(.LRST_SUPPORT(1'b0)) uut_nolr (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_nolr), .prog_fl_cap(prog_fl_cap),
    .async_en(n_async), .periodic_en(n_periodic), .fl_size(n_fls),
    .fidx_mask(n_mask), .lrst_req(n_lrst), .evict_done(evict_done),
    .lrst_done(lrst_done), .thr_tick(thr_tick), .irq(n_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    if (a == 'h0 && d[6] && !async_en) viol++;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse_evict(input logic tick);
    @(negedge clk);
    evict_done = 1'b1; thr_tick = tick;
    @(negedge clk);
    evict_done = 1'b0; thr_tick = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); thr_tick = 1'b1;
    @(negedge clk); thr_tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd('h0, d); chk("R1 cmd", d, 0);
    rd('h4, d); chk("R1 sts", d, 0);
    rd('h8, d); chk("R1 ien", d, 0);
    chk("R1 outs", {async_en, periodic_en, lrst_req, irq, fl_size}, 0);
    chk("R1 mask", fidx_mask, 'h3FF);
  endtask

  task automatic t_sched();
    logic [31:0] d;
    wr('h0, 'h30); rd('h0, d);
    chk("R2 both on", d, 'h30);
    chk("R2 outs", {async_en, periodic_en}, 2'b11);
    wr('h0, 'h10); rd('h0, d);
    chk("R2 pse only", {async_en, periodic_en}, 2'b01);
    wr('h0, 'h20);
    chk("R2 ase only", {async_en, periodic_en}, 2'b10);
  endtask

  task automatic t_fls();
    logic [31:0] d;
    prog_fl_cap = 1'b0;
    wr('h0, 'h24); rd('h0, d);
    chk("R3 locked", d, 'h20);
    chk("R4 mask 1024", fidx_mask, 'h3FF);
    prog_fl_cap = 1'b1;
    wr('h0, 'h24);
    chk("R3 fls 01", fl_size, 2'b01);
    chk("R4 mask 512", fidx_mask, 'h1FF);
    wr('h0, 'h28);
    chk("R4 mask 256", fidx_mask, 'h0FF);
    wr('h0, 'h2C); rd('h0, d);
    chk("R3 reserved ignored", d, 'h28);
    wr('h0, 'h20);
    chk("R3 back to 00", fl_size, 2'b00);
    prog_fl_cap = 1'b0;
    wr('h0, 'h28);
    chk("R3 locked again", fl_size, 2'b00);
  endtask

  task automatic t_doorbell();
    logic [31:0] d;
    wr('h0, 'h60); rd('h0, d);
    chk("R5 doorbell set", d, 'h60);
    wr('h0, 'h20); rd('h0, d);
    chk("R5 zero no effect", d, 'h60);
    pulse_evict(1'b0);
    rd('h0, d); chk("R6 doorbell cleared", d, 'h20);
    rd('h4, d); chk("R6 status set", d, 'h20);
  endtask

  task automatic t_ignore();
    logic [31:0] d;
    wr('h4, 'h20); rd('h4, d);
    chk("R9 w1c status", d, 0);
    pulse_evict(1'b0);
    rd('h4, d); chk("R7 status unchanged", d, 0);
    rd('h0, d); chk("R7 doorbell unchanged", d, 'h20);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    // enable off: tick must not fire
    wr('h0, 'h60); pulse_evict(1'b0); pulse_tick();
    chk("R8 no irq when disabled", irq, 0);
    wr('h4, 'h20);
    wr('h8, 'h20); rd('h8, d);
    chk("R8 enable readback", d, 'h20);
    // tick coincident with eviction: status not yet visible
    wr('h0, 'h60); pulse_evict(1'b1);
    rd('h4, d); chk("R6 status after evict", d, 'h20);
    chk("R8 not immediate", irq, 0);
    repeat (3) @(negedge clk);
    chk("R8 wait for tick", irq, 0);
    pulse_tick();
    chk("R8 irq after tick", irq, 1);
    wr('h4, 'h20);
    chk("R9 irq dropped", irq, 0);
    // clear through enable
    wr('h0, 'h60); pulse_evict(1'b0); pulse_tick();
    chk("R8 irq again", irq, 1);
    wr('h8, 'h0);
    chk("R9 irq dropped by enable", irq, 0);
    wr('h4, 'h20);
  endtask

  task automatic t_lrst();
    logic [31:0] d;
    wr('h0, 'hA0); rd('h0, d);
    chk("R10 lrst set", d, 'hA0);
    chk("R10 nolr reads 0", rdata_nolr, 'h20);
    repeat (4) @(negedge clk);
    chk("R10 lrst held", lrst_req, 1);
    @(negedge clk); lrst_done = 1'b1;
    @(negedge clk); lrst_done = 1'b0;
    rd('h0, d); chk("R10 lrst cleared", d, 'h20);
  endtask

  task automatic t_rsvd();
    logic [31:0] d;
    wr('h0, 'hFFFF_FF33); rd('h0, d);
    chk("R11 reserved bits zero", d, 'h30);
    rd('hC, d); chk("R11 unmapped zero", d, 0);
    chk("R5 no doorbell while schedule off", viol, 0);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    prog_fl_cap = 1'b0; evict_done = 1'b0; lrst_done = 1'b0; thr_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sched();
    t_fls();
    t_doorbell();
    t_ignore();
    t_irq();
    t_lrst();
    t_rsvd();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule